// File: doc/BRIEF.md
# Adaptive-Threshold Foreground Extractor

This block separates foreground from background in the low-frequency (approximation) band of an image pair. It works in two phases. In the first phase it receives the filtered full-resolution pixels of a background frame and a current frame, side by side, one pair per valid cycle. It sums the absolute pixel differences over a whole frame and scales that sum down to a small frame-wide offset with one right shift. The shift amount is three bits more than the log2 of the frame's pixel count, so the result is the sum divided by eight times the pixel count.

In the second phase it receives the approximation coefficients of both images, aligned and qualified by one shared valid. Each coefficient has its own threshold: the background coefficient plus the frame-wide offset. The magnitude of the coefficient difference is formed by a max/min selection followed by a subtraction. That magnitude is forwarded when it is strictly greater than the threshold, and zero is forwarded otherwise. The offset is held between completed frames, so a decision run always uses a single constant offset.

Top module: `fg_mask_extract`

## Requirements
- R1: While reset is asserted and directly after it, `offs_ready`, `offs_val`, `fg_vld` and `fg_coef` are all zero.
- R2: Each pixel pair accepted with `pix_vld` high adds |`pix_bg` − `pix_cur`| to a frame sum. On the clock edge that accepts the 2^FRAME_LOG2-th pair, `offs_val` becomes frame sum >> (FRAME_LOG2+3) and `offs_ready` goes to 1. Before that edge, in the first frame, `offs_ready` stays 0.
- R3: The frame sum cannot overflow. With every pair at the full-scale difference (2^PIX_W − 1), `offs_val` equals floor((2^PIX_W − 1)/8), which is 31 for 8-bit pixels.
- R4: A cycle with `pix_vld` low is neither counted nor summed, whatever the pixel inputs hold.
- R5: `offs_val` keeps its value until the edge that completes the next frame. Each new frame's sum starts from zero, and `offs_ready` never falls once set.
- R6: A coefficient pair presented while `offs_ready` is 0 is ignored: `fg_vld` stays 0 and `fg_coef` stays 0.
- R7: When `coef_vld` and `offs_ready` are both high at a clock edge, `fg_vld` is 1 after that edge. `fg_coef` is then d = |`coef_cur` − `coef_ref`| if d > `coef_ref` + `offs_val`, and 0 otherwise.
- R8: A difference exactly equal to its threshold yields 0.
- R9: The threshold sum is formed without wrapping. A full-scale `coef_ref` with `coef_cur` = 0 and a nonzero offset yields 0.
- R10: Whenever `fg_vld` is 0, `fg_coef` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | Pixel pair valid |
| pix_bg | input | PIX_W | Filtered background pixel |
| pix_cur | input | PIX_W | Filtered current pixel |
| coef_vld | input | 1 | Coefficient pair valid |
| coef_ref | input | COEF_W | Background approximation coefficient |
| coef_cur | input | COEF_W | Current approximation coefficient |
| offs_ready | output | 1 | Frame offset available |
| offs_val | output | OFF_W | Frame-wide threshold offset |
| fg_vld | output | 1 | Foreground coefficient valid |
| fg_coef | output | COEF_W | Foreground coefficient or zero |

## Verification
Four frame patterns feed the offset path. Random pixels test the absolute-difference summing and the shift. Constant full-scale pairs test accumulator width. Pixel streams with idle cycles carrying garbage show that unqualified data is dropped. Identical frames give a zero offset. The decision path gets random coefficient pairs under two different offsets, which catches a wrong difference direction or an ignored offset. Directed pairs placed exactly at the threshold and one above it separate a strict comparison from an inclusive one. A full-scale reference shows whether the threshold sum wraps, and pairs sent before any offset exists test the gating.

// File: rtl/fgm_pkg.sv
package fgm_pkg;

   function automatic int unsigned fgm_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned fgm_off_width(input int unsigned acc_w, input int unsigned shift);
      return (acc_w > shift) ? (acc_w - shift) : 1;
   endfunction

endpackage

// File: rtl/fgm_absdiff.sv
module fgm_absdiff #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] d
);
   logic [W-1:0] hi, lo;

   always_comb begin
      if (a > b) begin
         hi = a;
         lo = b;
      end else begin
         hi = b;
         lo = a;
      end
      d = hi - lo;
   end
endmodule

// File: rtl/fgm_offset_accum.sv
module fgm_offset_accum #(
   parameter int unsigned PIX_W      = 8,
   parameter int unsigned FRAME_LOG2 = 16,
   parameter int unsigned ACC_W      = PIX_W + FRAME_LOG2,
   parameter int unsigned SHIFT      = FRAME_LOG2 + 3,
   parameter int unsigned OFF_W      = fgm_pkg::fgm_off_width(ACC_W, SHIFT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_vld,
   input  logic [PIX_W-1:0] pix_bg,
   input  logic [PIX_W-1:0] pix_cur,
   output logic             offs_ready,
   output logic [OFF_W-1:0] offs_val
);
   logic [PIX_W-1:0]      term;
   logic [ACC_W-1:0]      acc;
   logic [ACC_W:0]        sum_ext;
   logic [ACC_W-1:0]      total;
   logic [FRAME_LOG2-1:0] cnt;
   logic                  last;
   logic [OFF_W-1:0]      offs_next;

   initial begin
      assert (ACC_W >= PIX_W + FRAME_LOG2) else $error("accumulator too narrow for a frame");
      assert (FRAME_LOG2 >= 1) else $error("frame must hold at least two pixels");
   end

   fgm_absdiff #(.W(PIX_W)) u_pix_diff (.a(pix_bg), .b(pix_cur), .d(term));

   assign sum_ext = {1'b0, acc} + (ACC_W + 1)'(term);
   assign total   = sum_ext[ACC_W-1:0];
   assign last    = &cnt;

   generate
      if (ACC_W > SHIFT) begin : g_scaled
         assign offs_next = total[ACC_W-1:SHIFT];
      end else begin : g_underflow
         assign offs_next = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc        <= '0;
         cnt        <= '0;
         offs_ready <= 1'b0;
         offs_val   <= '0;
      end else if (pix_vld) begin
         cnt <= cnt + 1'b1;
         if (last) begin
            acc        <= '0;
            offs_val   <= offs_next;
            offs_ready <= 1'b1;
         end else begin
            acc <= total;
         end
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld |-> !sum_ext[ACC_W]);

   assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      offs_ready |=> offs_ready);

   assert_offset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_vld && last) |=> $stable(offs_val));

   assert_idle_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld |=> $stable(cnt) && $stable(acc));
endmodule

// File: rtl/fgm_decide.sv
module fgm_decide #(
   parameter int unsigned COEF_W = 10,
   parameter int unsigned OFF_W  = 5,
   parameter int unsigned THR_W  = fgm_pkg::fgm_max(COEF_W, OFF_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              coef_vld,
   input  logic [COEF_W-1:0] coef_ref,
   input  logic [COEF_W-1:0] coef_cur,
   input  logic [OFF_W-1:0]  offs,
   output logic              fg_vld,
   output logic [COEF_W-1:0] fg_coef
);
   logic [COEF_W-1:0] diff;
   logic [THR_W-1:0]  thr;
   logic              pass;

   initial begin
      assert (THR_W > COEF_W && THR_W > OFF_W) else $error("threshold width may wrap");
   end

   fgm_absdiff #(.W(COEF_W)) u_coef_diff (.a(coef_ref), .b(coef_cur), .d(diff));

   assign thr  = THR_W'(coef_ref) + THR_W'(offs);
   assign pass = THR_W'(diff) > thr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fg_vld  <= 1'b0;
         fg_coef <= '0;
      end else if (coef_vld && enable) begin
         fg_vld  <= 1'b1;
         fg_coef <= pass ? diff : '0;
      end else begin
         fg_vld  <= 1'b0;
         fg_coef <= '0;
      end
   end

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !fg_vld |-> fg_coef == '0);

   assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fg_vld |-> $past(coef_vld) && $past(enable));

   assert_above_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fg_coef != '0) |-> fg_coef > $past(coef_ref));
endmodule

// File: rtl/fg_mask_extract.sv
module fg_mask_extract #(
   parameter int unsigned PIX_W      = 8,
   parameter int unsigned FRAME_LOG2 = 16,
   parameter int unsigned COEF_W     = 10,
   localparam int unsigned ACC_W     = PIX_W + FRAME_LOG2,
   localparam int unsigned SHIFT     = FRAME_LOG2 + 3,
   localparam int unsigned OFF_W     = fgm_pkg::fgm_off_width(ACC_W, SHIFT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_vld,
   input  logic [PIX_W-1:0]  pix_bg,
   input  logic [PIX_W-1:0]  pix_cur,
   input  logic              coef_vld,
   input  logic [COEF_W-1:0] coef_ref,
   input  logic [COEF_W-1:0] coef_cur,
   output logic              offs_ready,
   output logic [OFF_W-1:0]  offs_val,
   output logic              fg_vld,
   output logic [COEF_W-1:0] fg_coef
);
   initial begin
      assert (PIX_W >= 1 && COEF_W >= PIX_W) else $error("coefficient narrower than pixel");
   end

   fgm_offset_accum #(
      .PIX_W(PIX_W), .FRAME_LOG2(FRAME_LOG2), .ACC_W(ACC_W), .SHIFT(SHIFT), .OFF_W(OFF_W)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_bg(pix_bg), .pix_cur(pix_cur),
      .offs_ready(offs_ready), .offs_val(offs_val)
   );

   fgm_decide #(.COEF_W(COEF_W), .OFF_W(OFF_W)) u_decide (
      .clk(clk), .rst_n(rst_n), .enable(offs_ready), .coef_vld(coef_vld),
      .coef_ref(coef_ref), .coef_cur(coef_cur), .offs(offs_val),
      .fg_vld(fg_vld), .fg_coef(fg_coef)
   );

   assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !offs_ready |=> !fg_vld);
endmodule

// File: tb/fg_mask_extract_tb_top.sv
module fg_mask_extract_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 8;
   localparam int FL = 8;
   localparam int CW = 10;
   localparam int NPIX = 1 << FL;
   localparam int SH = FL + 3;
   localparam int OW = PW + FL - SH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_vld = 1'b0;
   logic [PW-1:0] pix_bg = '0, pix_cur = '0;
   logic coef_vld = 1'b0;
   logic [CW-1:0] coef_ref = '0, coef_cur = '0;
   logic offs_ready;
   logic [OW-1:0] offs_val;
   logic fg_vld;
   logic [CW-1:0] fg_coef;

   int total = 0, bad = 0, cyc = 0, s_now = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fg_mask_extract #(.PIX_W(PW), .FRAME_LOG2(FL), .COEF_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_bg(pix_bg), .pix_cur(pix_cur),
      .coef_vld(coef_vld), .coef_ref(coef_ref), .coef_cur(coef_cur),
      .offs_ready(offs_ready), .offs_val(offs_val), .fg_vld(fg_vld), .fg_coef(fg_coef)
   );

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   function automatic int exp_fg(input int r, input int c, input int s);
      int d = absd(r, c);
      return (d > r + s) ? d : 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000 && !finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // mode 0 random, 1 full-scale, 2 identical, 3 random with idle gaps
   task automatic feed_frame(input int mode, input bit first, input int prev_s);
      int sum = 0;
      for (int i = 0; i < NPIX; i++) begin
         if (mode == 3 && (i % 5) == 0) begin
            @(negedge clk);
            pix_vld = 1'b0;
            pix_bg  = PW'($urandom);
            pix_cur = PW'($urandom);
         end
         @(negedge clk);
         if (first && i == NPIX - 1) chk("R2 not ready before last pair", int'(offs_ready), 0);
         if (!first && i == NPIX / 2) chk("R5 offset held mid-frame", int'(offs_val), prev_s);
         pix_vld = 1'b1;
         case (mode)
            1: begin pix_bg = '1; pix_cur = '0; end
            2: begin pix_bg = PW'($urandom); pix_cur = pix_bg; end
            default: begin pix_bg = PW'($urandom); pix_cur = PW'($urandom); end
         endcase
         sum += absd(int'(pix_bg), int'(pix_cur));
      end
      @(posedge clk);
      #1;
      pix_vld = 1'b0;
      s_now = sum >> SH;
      chk("R2 offset ready after frame", int'(offs_ready), 1);
      chk("R2 offset value", int'(offs_val), s_now);
   endtask

   task automatic apply(input string req, input int r, input int c);
      @(negedge clk);
      coef_vld = 1'b1;
      coef_ref = CW'(r);
      coef_cur = CW'(c);
      @(posedge clk);
      #1;
      chk(req, int'(fg_vld), 1);
      chk(req, int'(fg_coef), exp_fg(r, c, s_now));
      @(negedge clk);
      coef_vld = 1'b0;
      coef_ref = CW'($urandom);
      coef_cur = CW'($urandom);
      @(posedge clk);
      #1;
      chk("R10 idle output zero", int'(fg_vld), 0);
      chk("R10 idle output zero", int'(fg_coef), 0);
   endtask

   initial begin
      int prev;
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset offs_ready", int'(offs_ready), 0);
      chk("R1 reset offs_val", int'(offs_val), 0);
      chk("R1 reset fg_vld", int'(fg_vld), 0);
      chk("R1 reset fg_coef", int'(fg_coef), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: coefficients before any offset
      @(negedge clk);
      coef_vld = 1'b1; coef_ref = '0; coef_cur = 10'd500;
      @(posedge clk);
      #1;
      chk("R6 gated fg_vld", int'(fg_vld), 0);
      chk("R6 gated fg_coef", int'(fg_coef), 0);
      @(negedge clk);
      coef_vld = 1'b0;

      feed_frame(0, 1'b1, 0);
      for (int k = 0; k < 150; k++) apply("R7 random decision", int'($urandom_range(1023)), int'($urandom_range(1023)));
      apply("R8 equal to threshold", 100, 200 + s_now);
      apply("R7 one above threshold", 100, 201 + s_now);
      apply("R9 full-scale reference", 1023, 0);

      prev = s_now;
      feed_frame(1, 1'b0, prev);
      chk("R3 full-scale offset", s_now, 31);
      for (int k = 0; k < 100; k++) apply("R7 random decision", int'($urandom_range(300)), int'($urandom_range(1023)));
      apply("R9 full-scale reference", 1023, 0);
      apply("R8 equal to threshold", 50, 131);
      apply("R7 one above threshold", 50, 132);

      prev = s_now;
      feed_frame(3, 1'b0, prev);
      apply("R4 decision after gapped frame", 20, 900);

      prev = s_now;
      feed_frame(2, 1'b0, prev);
      chk("R5 fresh sum zero offset", int'(offs_val), 0);
      apply("R8 equal with zero offset", 5, 0);
      apply("R7 above with zero offset", 5, 11);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule